// File: doc/BRIEF.md
# Mode-Dependent Bit-Rate Tick Generator

This block turns a fast system clock into the timing strobes of a serial port. A programmable 8-bit value N sets a first divide stage that fires once every N+1 clocks. A second, fixed prescale stage then counts those firings. Its ratio is 4, 16 or 64, picked by a synchronous-mode select and a high-speed select. The result is a one-clock bit tick at the serial bit rate. For the asynchronous receiver, the block also gives an oversampling tick at sixteen times the bit rate, taken from the first stage.

Software-side logic writes N through a load strobe. The load restarts both stages at once, so the new rate applies from that clock on. Toggling either select also restarts the count, so no tick is ever produced from a period that mixed two settings. The shift registers that use the ticks sit outside this block.

Top module: `bitrate_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both tick outputs are low; the divisor resets to 0 and the selects are taken as slow asynchronous.
- R2: The first stage fires once every N+1 clocks, where N is the last loaded divisor; in high-speed asynchronous mode this shows as `sampleTick` with period N+1 (high every cycle when N is 0).
- R3: With `syncSel`=1, whatever `fastSel` is, `bitTick` has period 4*(N+1) and `sampleTick` stays low.
- R4: With `syncSel`=0 and `fastSel`=1, `bitTick` has period 16*(N+1).
- R5: With `syncSel`=0 and `fastSel`=0, `bitTick` has period 64*(N+1).
- R6: In asynchronous mode, `sampleTick` fires 16 times per bit period, evenly spaced, and is high in every cycle in which `bitTick` is high.
- R7: A clock edge with `divisorLoad`=1 captures `divisorIn`. Counting that edge as edge 0, the first `bitTick` is high in the cycle after edge M*(N+1), where M is the mode multiplier.
- R8: A clock edge at which `{syncSel,fastSel}` differs from its value at the previous edge restarts both stages. The first `bitTick` then follows M*(N+1) edges later, as in R7.
- R9: `bitTick` is never high in two consecutive cycles.
- R10: In the cycle after a load edge or a select-change edge, both ticks are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| divisorIn | input | 8 | New divisor value N |
| divisorLoad | input | 1 | Capture `divisorIn` and restart the count |
| syncSel | input | 1 | 1: synchronous mode (x4 prescale) |
| fastSel | input | 1 | Async only: 1 selects x16, 0 selects x64 |
| bitTick | output | 1 | One-clock pulse at the bit rate |
| sampleTick | output | 1 | Pulse at 16x bit rate in async mode |

## Verification
Both ticks are registered. A tick caused by the k-th clock edge after a restart is therefore visible in the cycle after that edge, and a restart edge itself leaves both outputs low for one cycle. The bench changes inputs just after a falling edge. It advances a behavioural model at each rising edge by counting edges since the last restart, and compares both outputs at the next falling edge. Period checks count falling edges between pulses. The first-tick checks after a load or select change expect the pulse at falling edge M*(N+1)+1 after the change.

// File: rtl/bitrate_pkg.sv
package bitrate_pkg;

  typedef enum logic [1:0] {
    MODE_SLOW = 2'b00,
    MODE_FAST = 2'b01,
    MODE_SYNC = 2'b10
  } rateMode_e;

  // strobes from control to the divide datapath
  typedef struct packed {
    logic capture;   // take a new divisor and reload from it
    logic restart;   // reload the down-counter from the held divisor
  } dpCtrl_t;

  function automatic rateMode_e decodeMode(input logic syncBit, input logic fastBit);
    if (syncBit)      return MODE_SYNC;
    else if (fastBit) return MODE_FAST;
    else              return MODE_SLOW;
  endfunction

endpackage

// File: rtl/bitrate_dp.sv
module bitrate_dp
  import bitrate_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          dpCtrl,
  input  logic [DIV_W-1:0] divisorIn,
  output logic             divTick
);

  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] divCnt;
  logic             atZero;

  assign atZero  = (divCnt == '0);
  assign divTick = atZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divReg <= '0;
      divCnt <= '0;
    end else if (dpCtrl.capture) begin
      divReg <= divisorIn;
      divCnt <= divisorIn;
    end else if (dpCtrl.restart || atZero) begin
      divCnt <= divReg;
    end else begin
      divCnt <= divCnt - 1'b1;
    end
  end

  // R7: a load puts the new value straight into the counter
  assert_load_reloads_R7: assert property (@(posedge clk) disable iff (!rstN)
    dpCtrl.capture |=> (divCnt == $past(divisorIn)));

  // R2: count reaches zero, then reloads from the held divisor
  assert_zero_reload_R2: assert property (@(posedge clk) disable iff (!rstN)
    (atZero && !dpCtrl.capture) |=> (divCnt == divReg));

endmodule

// File: rtl/bitrate_ctrl.sv
module bitrate_ctrl
  import bitrate_pkg::*;
#(
  parameter int SYNC_MULT = 4,
  parameter int FAST_MULT = 16,
  parameter int SLOW_MULT = 64,
  parameter int OVS       = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    syncSel,
  input  logic    fastSel,
  input  logic    divisorLoad,
  input  logic    divTick,
  output dpCtrl_t dpCtrl,
  output logic    bitTick,
  output logic    sampleTick
);

  localparam int PRE_W     = $clog2(SLOW_MULT);
  localparam int FAST_SDIV = FAST_MULT / OVS;
  localparam int SLOW_SDIV = SLOW_MULT / OVS;
  localparam int SMP_W     = $clog2(SLOW_SDIV + 1);

  localparam logic [PRE_W-1:0] SYNC_LAST = PRE_W'(SYNC_MULT - 1);
  localparam logic [PRE_W-1:0] FAST_LAST = PRE_W'(FAST_MULT - 1);
  localparam logic [PRE_W-1:0] SLOW_LAST = PRE_W'(SLOW_MULT - 1);
  localparam logic [SMP_W-1:0] FAST_SLAST = SMP_W'(FAST_SDIV - 1);
  localparam logic [SMP_W-1:0] SLOW_SLAST = SMP_W'(SLOW_SDIV - 1);

  logic [1:0]       selNow;
  logic [1:0]       selQ;
  logic             selChg;
  logic             restart;
  rateMode_e        modeNow;
  rateMode_e        modeQ;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLast;
  logic [PRE_W-1:0] preLastQ;
  logic [SMP_W-1:0] smpCnt;
  logic [SMP_W-1:0] smpLast;
  logic             preWrap;
  logic             smpWrap;
  logic             stageFire;

  assign selNow    = {syncSel, fastSel};
  assign selChg    = (selNow != selQ);
  assign restart   = divisorLoad || selChg;
  assign modeNow   = decodeMode(syncSel, fastSel);
  assign modeQ     = decodeMode(selQ[1], selQ[0]);
  assign stageFire = divTick && !restart;

  assign dpCtrl.capture = divisorLoad;
  assign dpCtrl.restart = restart;

  always_comb begin
    unique case (modeNow)
      MODE_SYNC: begin preLast = SYNC_LAST; smpLast = '0;         end
      MODE_FAST: begin preLast = FAST_LAST; smpLast = FAST_SLAST; end
      default:   begin preLast = SLOW_LAST; smpLast = SLOW_SLAST; end
    endcase
  end

  always_comb begin
    unique case (modeQ)
      MODE_SYNC: preLastQ = SYNC_LAST;
      MODE_FAST: preLastQ = FAST_LAST;
      default:   preLastQ = SLOW_LAST;
    endcase
  end

  assign preWrap = (preCnt == preLast);
  assign smpWrap = (smpCnt == smpLast);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ       <= 2'b00;
      preCnt     <= '0;
      smpCnt     <= '0;
      bitTick    <= 1'b0;
      sampleTick <= 1'b0;
    end else begin
      selQ <= selNow;
      if (restart) begin
        preCnt     <= '0;
        smpCnt     <= '0;
        bitTick    <= 1'b0;
        sampleTick <= 1'b0;
      end else if (stageFire) begin
        preCnt     <= preWrap ? '0 : preCnt + 1'b1;
        smpCnt     <= smpWrap ? '0 : smpCnt + 1'b1;
        bitTick    <= preWrap;
        sampleTick <= (modeNow != MODE_SYNC) && smpWrap;
      end else begin
        bitTick    <= 1'b0;
        sampleTick <= 1'b0;
      end
    end
  end

  // R9: bit tick lasts exactly one clock
  assert_bit_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |=> !bitTick);

  // R10: nothing comes out of the cycle after a restart
  assert_restart_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (!bitTick && !sampleTick));

  // R3: synchronous mode never oversamples
  assert_sync_nosample_R3: assert property (@(posedge clk) disable iff (!rstN)
    sampleTick |-> !$past(syncSel));

  // R6: in async mode every bit tick is also a sample tick
  assert_bit_on_sample_R6: assert property (@(posedge clk) disable iff (!rstN)
    (bitTick && !sampleTick) |-> $past(syncSel));

  // R5: prescale count stays inside the ratio of the mode it counts for
  assert_pre_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= preLastQ);

endmodule

// File: rtl/bitrate_gen.sv
module bitrate_gen
  import bitrate_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int SYNC_MULT = 4,
  parameter int FAST_MULT = 16,
  parameter int SLOW_MULT = 64,
  parameter int OVS       = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisorIn,
  input  logic             divisorLoad,
  input  logic             syncSel,
  input  logic             fastSel,
  output logic             bitTick,
  output logic             sampleTick
);

  dpCtrl_t dpCtrl;
  logic    divTick;

  bitrate_ctrl #(
    .SYNC_MULT(SYNC_MULT),
    .FAST_MULT(FAST_MULT),
    .SLOW_MULT(SLOW_MULT),
    .OVS      (OVS)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .syncSel    (syncSel),
    .fastSel    (fastSel),
    .divisorLoad(divisorLoad),
    .divTick    (divTick),
    .dpCtrl     (dpCtrl),
    .bitTick    (bitTick),
    .sampleTick (sampleTick)
  );

  bitrate_dp #(
    .DIV_W(DIV_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .dpCtrl   (dpCtrl),
    .divisorIn(divisorIn),
    .divTick  (divTick)
  );

endmodule

// File: tb/sim_bitrate_gen.sv
`timescale 1ns/1ps
module sim_bitrate_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] divisorIn = 8'd0;
  logic       divisorLoad = 1'b0;
  logic       syncSel = 1'b0;
  logic       fastSel = 1'b0;
  logic       bitTick;
  logic       sampleTick;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  bitrate_gen u0 (
    .clk(clk), .rstN(rstN), .divisorIn(divisorIn), .divisorLoad(divisorLoad),
    .syncSel(syncSel), .fastSel(fastSel), .bitTick(bitTick), .sampleTick(sampleTick)
  );

  // behavioural reference: edges since last restart
  int  mEdges = 0;
  int  mDiv   = 0;
  bit  mSync  = 0, mFast = 0;
  bit  expBit = 0, expSmp = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mEdges = 0; mDiv = 0; mSync = 0; mFast = 0; expBit = 0; expSmp = 0;
    end else begin
      bit chg;
      chg = (syncSel != mSync) || (fastSel != mFast);
      mSync = syncSel; mFast = fastSel;
      if (divisorLoad) begin
        mDiv = divisorIn; mEdges = 0; expBit = 0; expSmp = 0;
      end else if (chg) begin
        mEdges = 0; expBit = 0; expSmp = 0;
      end else begin
        mEdges++;
        if (mEdges % (mDiv + 1) == 0) begin
          int j, mult;
          j = mEdges / (mDiv + 1);
          mult = mSync ? 4 : (mFast ? 16 : 64);
          expBit = (j % mult == 0);
          expSmp = !mSync && (mFast || (j % 4 == 0));
        end else begin
          expBit = 0; expSmp = 0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", what, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  // per-cycle comparison with the model, plus watchdog
  always @(negedge clk) begin
    cycles++;
    if (!done) begin
      check(bitTick === expBit, "R3/R4/R5/R7/R8 bitTick vs model", int'(bitTick), int'(expBit));
      check(sampleTick === expSmp, "R2/R6 sampleTick vs model", int'(sampleTick), int'(expSmp));
    end
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      check(1'b0, "watchdog expired", cycles, 190000);
      finishRun();
    end
  end

  task automatic drive();
    @(negedge clk); #0.5;
  endtask

  task automatic loadDiv(input int n);
    drive(); divisorIn = 8'(n); divisorLoad = 1'b1;
    drive(); divisorLoad = 1'b0;
    // R10: first output cycle after the load edge is quiet
    check(!bitTick && !sampleTick, "R10 ticks after load", int'(bitTick | sampleTick), 0);
  endtask

  task automatic setSel(input bit s, input bit f);
    drive(); syncSel = s; fastSel = f;
  endtask

  // count falling edges from the input change until the first bitTick
  task automatic firstBit(input int exp, input string tag);
    int n = 0;
    while (n < 20000) begin
      @(negedge clk); n++;
      if (bitTick) break;
    end
    check(n == exp, tag, n, exp);
  endtask

  task automatic measure(input bit useSmp, input int exp, input string tag);
    int n = 0;
    int guard = 0;
    while (!(useSmp ? sampleTick : bitTick) && guard < 20000) begin
      @(negedge clk); guard++;
    end
    @(negedge clk); n = 1;
    if (!useSmp) check(!bitTick, "R9 bitTick pulse width", int'(bitTick), 0);
    while (!(useSmp ? sampleTick : bitTick) && n < 20000) begin
      @(negedge clk); n++;
    end
    check(n == exp, tag, n, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!bitTick && !sampleTick, "R1 ticks low in reset", int'(bitTick | sampleTick), 0);
    drive(); rstN = 1'b1;
    @(negedge clk);
    check(!bitTick && !sampleTick, "R1 ticks low after reset", int'(bitTick | sampleTick), 0);

    measure(0, 64, "R5 slow period N=0");
    measure(1, 4,  "R6 slow sample period N=0");

    loadDiv(3);
    firstBit(64*4, "R7 first bit after load N=3");
    measure(0, 256, "R5 slow period N=3");
    measure(1, 16,  "R6 slow sample period N=3");

    setSel(1, 0);
    firstBit(4*4+1, "R8 first bit after select change");
    measure(0, 16, "R3 sync period N=3");
    begin
      int seen = 0;
      repeat (100) begin @(negedge clk); if (sampleTick) seen++; end
      check(seen == 0, "R3 no sampleTick in sync", seen, 0);
    end
    setSel(1, 1);
    firstBit(4*4+1, "R8 restart on fastSel while sync");
    measure(0, 16, "R3 sync period with fastSel set");

    setSel(0, 1);
    firstBit(16*4+1, "R8 first bit after entering fast");
    measure(0, 64, "R4 fast period N=3");
    measure(1, 4,  "R2 fast sample period N=3");

    loadDiv(0);
    measure(1, 1,  "R2 fast sample every cycle N=0");
    measure(0, 16, "R4 fast period N=0");

    loadDiv(255);
    setSel(1, 0);
    measure(0, 1024, "R3 sync period N=255");
    setSel(0, 0);
    firstBit(64*256+1, "R8 first slow bit N=255");
    measure(1, 1024, "R6 slow sample period N=255");

    drive(); rstN = 1'b0;
    drive(); rstN = 1'b1;
    measure(0, 64, "R1 divisor back to 0 after reset");

    done = 1'b1;
    finishRun();
  end

endmodule